// File: doc/BRIEF.md
# Polled SPI Master with Register Interface

This block is a serial peripheral master that software drives through a small 32-bit register window. Software places one or more words in an eight-entry transmit queue, sets a start bit in the control register, and polls until the start bit drops or the receive-ready flag rises. Each received word lands in an eight-entry receive queue that software drains by reading the receive register.

The control register picks the word length (1 to 32 bits, coded as length minus one), the idle level of the serial clock, which clock edge samples data, the active level of the chip selects, one of four chip-select outputs and a 3-bit clock divider code. A test register can route the outgoing data line straight back into the receive path so that the block can check itself without a slave attached. A period register is held and read back but drives nothing.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x01, control (0x08) reads 0, every chip-select output is high, and the serial clock and data-out lines are low.
- R2: Control bits [4:0] hold the word length minus one; a word of length N shifts out on the data-out line most significant bit first, starting from bit N-1 of the transmit word, and the N bits sampled from data-in form the received word, right aligned with zeros above.
- R3: Control bit 5 set makes the serial clock idle high; control bit 6 clear samples on the first clock edge of each bit and changes data on the second, and control bit 6 set does the opposite.
- R4: Control bits [16:14] hold a divider code D; every serial clock half-period inside a word lasts 2^(D+1) system clocks.
- R5: Control bits [20:19] pick which of four chip-select outputs is asserted during an exchange, control bit 8 set makes the asserted level high, and all other outputs stay at the inactive level; with enable (control bit 10) clear, all four stay inactive.
- R6: Writing control with bit 9 set and bit 10 set starts an exchange; bit 9 reads back 1 while words remain or one is shifting, clears by itself once the transmit queue is empty and the last word has been stored, and the chip select deasserts then. Writing bit 9 with bit 10 clear starts nothing.
- R7: Reading offset 0x00 pops one received word; status bit 4 is set while the receive queue holds any word, bit 5 while it holds at least four, bit 6 when it holds eight.
- R8: A word completing while the receive queue is full is dropped and sets status bit 7, which stays set until software writes status with bit 7 set.
- R9: Writing offset 0x04 pushes a word to the transmit queue; status bit 0 is set when it is empty, bit 1 when it holds at least four, bit 2 when it holds eight, and a write while full is dropped.
- R10: With test register (0x10) bit 14 set, the received word equals the transmitted word and the data-in pin is ignored.
- R11: Control reads back every implemented field at its position, the test register reads back bit 14, and the period register (0x14) reads back the full 32-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of 0x00 pops the receive queue |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select outputs |

## Verification
The hardest condition to reach from the ports is a word completing into a full receive queue while the transmit side still sends, because software normally drains after every word. The bench fills the transmit queue to its limit with the block disabled, adds one word that must be dropped, then runs eight words in loopback without reading so that the receive queue fills exactly, and a single further word then provokes the overflow. The bench also plays a slave that answers with a known pattern and records the outgoing bits, chip selects and half-period lengths on each sampling edge across every word length and clock mode.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Byte offsets of the register window
  localparam int unsigned OFS_RXD = 0;
  localparam int unsigned OFS_TXD = 4;
  localparam int unsigned OFS_CTL = 8;
  localparam int unsigned OFS_STA = 12;
  localparam int unsigned OFS_TST = 16;
  localparam int unsigned OFS_PER = 20;

  // Control field positions
  localparam int unsigned C_CPOL   = 5;
  localparam int unsigned C_CPHA   = 6;
  localparam int unsigned C_SSCTL  = 7;
  localparam int unsigned C_SSPOL  = 8;
  localparam int unsigned C_XCH    = 9;
  localparam int unsigned C_EN     = 10;
  localparam int unsigned C_MSTR   = 11;
  localparam int unsigned C_DIV_LO = 14;
  localparam int unsigned C_CS_LO  = 19;

  // Status bit positions
  localparam int unsigned S_TE  = 0;
  localparam int unsigned S_TH  = 1;
  localparam int unsigned S_TF  = 2;
  localparam int unsigned S_RR  = 4;
  localparam int unsigned S_RH  = 5;
  localparam int unsigned S_RF  = 6;
  localparam int unsigned S_OVF = 7;

  // Test register
  localparam int unsigned T_LOOP = 14;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic [$clog2(DEPTH+1)-1:0]     cnt,
  output logic                           full,
  output logic                           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        start,
  input  logic [DATA_W-1:0]           word,
  input  logic [$clog2(DATA_W)-1:0]   len_m1,
  input  logic                        cpol,
  input  logic                        cpha,
  input  logic [DIV_W-1:0]            div,
  input  logic                        loop,
  input  logic                        miso,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rx_word,
  output logic                        sclk,
  output logic                        mosi
);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int ECW   = LEN_W + 1;
  localparam int TMR_W = 1 << DIV_W;

  logic [TMR_W:0]      half;
  logic [TMR_W-1:0]    half_m1, tmr;
  logic [ECW-1:0]      ecnt;
  logic [DATA_W-1:0]   sh, rx, sh_init, rx_nxt;
  logic [LEN_W-1:0]    algn;
  logic                lead, smp, last, bit_in;

  always_comb begin
    half    = {{TMR_W{1'b0}}, 1'b1} << ({1'b0, div} + 1'b1);
    half_m1 = TMR_W'(half - 1'b1);
    algn    = LEN_W'(DATA_W - 1) - len_m1;
    sh_init = word << algn;
    lead    = ~ecnt[0];
    smp     = lead ^ cpha;
    last    = (ecnt == {len_m1, 1'b1});
    bit_in  = loop ? mosi : miso;
    rx_nxt  = {rx[DATA_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      tmr     <= '0;
      ecnt    <= '0;
      sh      <= '0;
      rx      <= '0;
      rx_word <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        tmr  <= '0;
        ecnt <= '0;
        if (start && en) begin
          busy <= 1'b1;
          rx   <= '0;
          if (cpha) begin
            sh <= sh_init;
          end else begin
            mosi <= sh_init[DATA_W-1];
            sh   <= sh_init << 1;
          end
        end
      end else if (!en) begin
        busy <= 1'b0;
        sclk <= cpol;
      end else if (tmr == half_m1) begin
        tmr  <= '0;
        sclk <= ~sclk;
        ecnt <= ecnt + 1'b1;
        if (smp) begin
          rx <= rx_nxt;
        end else begin
          mosi <= sh[DATA_W-1];
          sh   <= sh << 1;
        end
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= smp ? rx_nxt : rx;
        end
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 3,
  parameter int NUM_CS     = 4,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int CSEL_W = $clog2(NUM_CS);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  // control state
  logic [LEN_W-1:0]  len_m1;
  logic [DIV_W-1:0]  div;
  logic [CSEL_W-1:0] csel;
  logic              cpol, cpha, ssctl, sspol, xch, en, mstr, loop, ovf, sess;
  logic [DATA_W-1:0] period;

  // decode
  logic wr_txd, wr_ctl, wr_sta, wr_tst, wr_per, rd_rxd, wr_sta_clr;
  assign wr_txd     = bus_wr && (bus_addr == ADDR_W'(OFS_TXD));
  assign wr_ctl     = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign wr_sta     = bus_wr && (bus_addr == ADDR_W'(OFS_STA));
  assign wr_tst     = bus_wr && (bus_addr == ADDR_W'(OFS_TST));
  assign wr_per     = bus_wr && (bus_addr == ADDR_W'(OFS_PER));
  assign rd_rxd     = bus_rd && (bus_addr == ADDR_W'(OFS_RXD));
  assign wr_sta_clr = wr_sta && bus_wdata[S_OVF];

  // queues
  logic [DATA_W-1:0] tx_head, rx_head, sh_rx;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_pop, sh_busy, sh_done, xch_done, ovf_set;

  assign tx_pop   = xch && !sh_busy && !tx_empty;
  assign xch_done = xch && !sh_busy && !sh_done && tx_empty;
  assign ovf_set  = sh_done && rx_full;

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_txd), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_head), .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(sh_done), .din(sh_rx), .pop(rd_rxd),
    .dout(rx_head), .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spim_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .en(en), .start(tx_pop), .word(tx_head),
    .len_m1(len_m1), .cpol(cpol), .cpha(cpha), .div(div), .loop(loop),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  // register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      len_m1 <= '0;
      div    <= '0;
      csel   <= '0;
      cpol   <= 1'b0;
      cpha   <= 1'b0;
      ssctl  <= 1'b0;
      sspol  <= 1'b0;
      xch    <= 1'b0;
      en     <= 1'b0;
      mstr   <= 1'b0;
      loop   <= 1'b0;
      period <= '0;
      ovf    <= 1'b0;
      sess   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        len_m1 <= bus_wdata[LEN_W-1:0];
        cpol   <= bus_wdata[C_CPOL];
        cpha   <= bus_wdata[C_CPHA];
        ssctl  <= bus_wdata[C_SSCTL];
        sspol  <= bus_wdata[C_SSPOL];
        en     <= bus_wdata[C_EN];
        mstr   <= bus_wdata[C_MSTR];
        div    <= bus_wdata[C_DIV_LO +: DIV_W];
        csel   <= bus_wdata[C_CS_LO +: CSEL_W];
        xch    <= bus_wdata[C_XCH] & bus_wdata[C_EN];
      end else if (xch_done) begin
        xch <= 1'b0;
      end
      if (wr_tst) loop   <= bus_wdata[T_LOOP];
      if (wr_per) period <= bus_wdata;
      if (ovf_set)         ovf <= 1'b1;
      else if (wr_sta_clr) ovf <= 1'b0;
      if (!en)           sess <= 1'b0;
      else if (tx_pop)   sess <= 1'b1;
      else if (xch_done) sess <= 1'b0;
    end
  end

  // chip selects, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      spi_cs <= '1;
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        spi_cs[i] <= (en && sess && (csel == CSEL_W'(i))) ? sspol : ~sspol;
      end
    end
  end

  // read mux
  logic [DATA_W-1:0] ctl_rd, sta_rd, rd_val;

  always_comb begin
    ctl_rd                        = '0;
    ctl_rd[LEN_W-1:0]             = len_m1;
    ctl_rd[C_CPOL]                = cpol;
    ctl_rd[C_CPHA]                = cpha;
    ctl_rd[C_SSCTL]               = ssctl;
    ctl_rd[C_SSPOL]               = sspol;
    ctl_rd[C_XCH]                 = xch;
    ctl_rd[C_EN]                  = en;
    ctl_rd[C_MSTR]                = mstr;
    ctl_rd[C_DIV_LO +: DIV_W]     = div;
    ctl_rd[C_CS_LO +: CSEL_W]     = csel;

    sta_rd        = '0;
    sta_rd[S_TE]  = tx_empty;
    sta_rd[S_TH]  = (tx_cnt >= CNT_W'(FIFO_DEPTH / 2));
    sta_rd[S_TF]  = tx_full;
    sta_rd[S_RR]  = !rx_empty;
    sta_rd[S_RH]  = (rx_cnt >= CNT_W'(FIFO_DEPTH / 2));
    sta_rd[S_RF]  = rx_full;
    sta_rd[S_OVF] = ovf;

    case (bus_addr)
      ADDR_W'(OFS_RXD): rd_val = rx_empty ? '0 : rx_head;
      ADDR_W'(OFS_CTL): rd_val = ctl_rd;
      ADDR_W'(OFS_STA): rd_val = sta_rd;
      ADDR_W'(OFS_TST): rd_val = DATA_W'(loop) << T_LOOP;
      ADDR_W'(OFS_PER): rd_val = period;
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int NCS   = 4,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           sspol,
  input logic           cpol,
  input logic           busy,
  input logic           sclk,
  input logic           ovf,
  input logic           ovf_clr,
  input logic           push_full,
  input logic [NCS-1:0] cs,
  input logic [CW-1:0]  rx_cnt,
  input logic [CW-1:0]  tx_cnt
);
  // R5: never more than one chip select active
  a_r5_single_cs: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $countones($past(sspol) ? cs : ~cs) <= 1);

  // R5: disabled block holds every select inactive
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> cs == {NCS{~$past(sspol)}});

  // R3: clock rests at the programmed idle level between words
  a_r3_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> sclk == $past(cpol));

  // R8: overflow is sticky until cleared
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);

  // R8: completion into a full queue raises overflow
  a_r8_ovf_set: assert property (@(posedge clk) disable iff (rst)
    push_full |=> ovf);

  // R7: receive occupancy bounded
  a_r7_rx_bound: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

  // R9: transmit occupancy bounded
  a_r9_tx_bound: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH));
endmodule

bind spim_ctrl spim_ctrl_chk #(.NCS(NUM_CS), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .sspol(sspol), .cpol(cpol), .busy(sh_busy),
  .sclk(spi_sclk), .ovf(ovf), .ovf_clr(wr_sta_clr), .push_full(ovf_set),
  .cs(spi_cs), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  // slave model state
  bit          m_arm = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_sspol = 1'b0, m_inv = 1'b0;
  int          m_len = 8, m_div = 0, m_sel = 0, m_ns = 0, m_edge = 0, m_last = 0;
  int          hp_bad = 0, cs_bad = 0;
  logic [31:0] m_pat = '0, mon_mosi = '0;
  logic [3:0]  m_cs_exp = '0;

  spim_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  always @(spi_sclk) begin
    if (m_arm && spi_cs != {4{~m_sspol}}) begin
      if (m_edge != 0 && (cyc - m_last) != (1 << (m_div + 1))) hp_bad++;
      m_last = cyc;
      m_edge++;
      if (m_edge == 2 * m_len) m_edge = 0;
      if ((spi_sclk != m_cpol) ^ m_cpha) begin
        mon_mosi = {mon_mosi[30:0], spi_mosi};
        if (spi_cs != m_cs_exp) cs_bad++;
        m_ns++;
        if (m_ns == m_len) m_ns = 0;
        spi_miso = m_pat[m_len - 1 - m_ns] ^ m_inv;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic logic [31:0] ctl(input int len, input bit cp, input bit ph, input int dv,
                                      input int sel, input bit ssp, input bit go);
    return 32'(len - 1) | (32'(cp) << 5) | (32'(ph) << 6) | (32'(ssp) << 8) |
           (32'(go) << 9) | (32'h1 << 10) | (32'h1 << 11) | (32'(dv) << 14) | (32'(sel) << 19);
  endfunction

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      rd(5'h08, d);
      if (!d[9]) break;
    end
  endtask

  task automatic xfer(input int len, input bit cp, input bit ph, input int dv, input int sel,
                      input bit ssp, input bit lb, input logic [31:0] tx,
                      input logic [31:0] pat, output logic [31:0] rx);
    m_len = len; m_cpol = cp; m_cpha = ph; m_div = dv; m_sel = sel; m_sspol = ssp;
    m_pat = pat; m_inv = lb; m_ns = 0; m_edge = 0; hp_bad = 0; cs_bad = 0; mon_mosi = '0;
    for (int i = 0; i < 4; i++) m_cs_exp[i] = (i == sel) ? ssp : ~ssp;
    spi_miso = pat[len - 1] ^ lb;
    wr(5'h10, 32'(lb) << 14);
    wr(5'h04, tx);
    m_arm = 1'b1;
    wr(5'h08, ctl(len, cp, ph, dv, sel, ssp, 1'b1));
    wait_idle();
    rd(5'h00, rx);
    m_arm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, tx, pat, rx, m;
    logic [31:0] q [9];
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h0C, d); check(d == 32'h01, "R1 status", d, 32'h01);
    rd(5'h08, d); check(d == 32'h0, "R1 control", d, 32'h0);
    check(spi_cs == 4'hF, "R1 cs", 32'(spi_cs), 32'hF);
    check({spi_sclk, spi_mosi} == 2'b00, "R1 sclk/mosi", 32'({spi_sclk, spi_mosi}), 32'h0);

    // R11 readback
    wr(5'h08, 32'hFFFF_FDFF);
    rd(5'h08, d); check(d == 32'h0019_CDFF, "R11 control readback", d, 32'h0019_CDFF);
    wr(5'h14, 32'hC0DE_8123);
    rd(5'h14, d); check(d == 32'hC0DE_8123, "R11 period readback", d, 32'hC0DE_8123);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, d); check(d == 32'h4000, "R11 test readback", d, 32'h4000);
    wr(5'h10, 32'h0);

    // R5 disabled select levels, R6 start ignored when disabled
    wr(5'h08, 32'h0000_0300);
    repeat (3) @(negedge clk);
    check(spi_cs == 4'h0, "R5 disabled cs high-active", 32'(spi_cs), 32'h0);
    rd(5'h08, d); check(d[9] == 1'b0, "R6 start ignored when disabled", d, 32'h100);
    wr(5'h08, 32'h0);
    repeat (3) @(negedge clk);
    check(spi_cs == 4'hF, "R5 disabled cs low-active", 32'(spi_cs), 32'hF);

    // R2 R3 R4 R5: sweep every length and mode against the slave model
    for (int len = 1; len <= 32; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        tx  = 32'h9E37_79B9 * 32'(len * 4 + mode + 1);
        pat = {tx[15:0], tx[31:16]} ^ 32'h5A5A_0FF0;
        m   = lmask(len);
        xfer(len, mode[1], mode[0], 0, (len + mode) % 4, len[0], 1'b0, tx, pat, rx);
        check(rx == (pat & m), "R2 R3 received word", rx, pat & m);
        check(mon_mosi == (tx & m), "R2 R3 transmitted bits", mon_mosi, tx & m);
        check(hp_bad == 0, "R4 half period div0", 32'(hp_bad), 0);
        check(cs_bad == 0, "R5 select during word", 32'(cs_bad), 0);
        check(spi_cs == {4{~len[0]}}, "R6 select released", 32'(spi_cs), 32'({4{~len[0]}}));
      end
    end

    // R4 every divider code
    for (int dv = 0; dv < 8; dv++) begin
      tx = 32'h0000_00A0 + 32'(dv * 7);
      xfer(8, dv[0], dv[1], dv, dv % 4, 1'b0, 1'b0, tx, 32'h0000_00C3, rx);
      check(hp_bad == 0, "R4 half period per divider", 32'(hp_bad), 0);
      check(rx == 32'hC3, "R4 data at divider", rx, 32'hC3);
    end

    // R10 loopback ignores data-in (driven inverted)
    for (int len = 1; len <= 32; len += 5) begin
      for (int mode = 0; mode < 4; mode++) begin
        tx = 32'hF00D_1234 ^ 32'(len * 977 + mode);
        xfer(len, mode[1], mode[0], 1, 2, 1'b1, 1'b1, tx, tx, rx);
        check(rx == (tx & lmask(len)), "R10 loopback word", rx, tx & lmask(len));
      end
    end

    // R6 start bit reads 1 during exchange
    wr(5'h10, 32'h4000);
    wr(5'h04, 32'h1234_5678);
    wr(5'h08, ctl(32, 1'b0, 1'b0, 2, 0, 1'b0, 1'b1));
    rd(5'h08, d); check(d[9] == 1'b1, "R6 start bit set while busy", d, d | 32'h200);
    wait_idle();
    rd(5'h0C, d); check(d == 32'h11, "R7 ready after exchange", d, 32'h11);
    rd(5'h00, d); check(d == 32'h1234_5678, "R10 long word", d, 32'h1234_5678);
    rd(5'h0C, d); check(d == 32'h01, "R7 ready clears after pop", d, 32'h01);

    // R9 transmit flags with block disabled, R8 overflow
    wr(5'h08, 32'h0);
    for (int i = 0; i < 9; i++) q[i] = 32'hAB00_0000 + 32'(i * 4099);
    for (int i = 0; i < 4; i++) wr(5'h04, q[i]);
    rd(5'h0C, d); check(d == 32'h02, "R9 half", d, 32'h02);
    for (int i = 4; i < 8; i++) wr(5'h04, q[i]);
    rd(5'h0C, d); check(d == 32'h06, "R9 full", d, 32'h06);
    wr(5'h04, 32'hDEAD_BEEF);
    rd(5'h0C, d); check(d == 32'h06, "R9 write while full", d, 32'h06);
    wr(5'h08, ctl(32, 1'b0, 1'b1, 0, 1, 1'b0, 1'b1));
    wait_idle();
    rd(5'h0C, d); check(d == 32'h71, "R7 receive full, no overflow", d, 32'h71);
    wr(5'h04, q[8]);
    wr(5'h08, ctl(32, 1'b0, 1'b1, 0, 1, 1'b0, 1'b1));
    wait_idle();
    rd(5'h0C, d); check(d == 32'hF1, "R8 overflow set", d, 32'hF1);
    for (int i = 0; i < 8; i++) begin
      rd(5'h00, d); check(d == q[i], "R7 R9 queue order", d, q[i]);
      if (i == 4) begin
        rd(5'h0C, d); check(d == 32'h91, "R7 below half", d, 32'h91);
      end
    end
    rd(5'h0C, d); check(d == 32'h81, "R8 overflow sticky, dropped word", d, 32'h81);
    wr(5'h0C, 32'h0000_007F);
    rd(5'h0C, d); check(d == 32'h81, "R8 clear needs bit 7", d, 32'h81);
    wr(5'h0C, 32'h80);
    rd(5'h0C, d); check(d == 32'h01, "R8 overflow cleared", d, 32'h01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule